// File: doc/BRIEF.md
# Interrupt Driveback Cycle Decoder

This block sits on the host side of a simplified PCI-style target port and turns interrupt driveback writes from devices into interrupt signalling. A device opens a cycle with an address and then presents one or two 32-bit data beats. Every beat carries its request values in the low sixteen bits and an active-low enable for each of those bits in the high sixteen bits, so a device touches only the lines it owns.

A beat at the base address (phase one) sets the levels of the sixteen legacy ISA interrupt lines. These levels feed an edge-detecting interrupt controller downstream. Two of those lines are reserved for other uses: IRQ2 drives a system-management request and IRQ13 drives a non-maskable request, and both keep active-high sense. A beat at base plus four (phase two) carries four level-mode PCI interrupt lines and four ACPI event lines. Phase two arrives either as the burst beat directly after phase one or as a cycle that goes straight to base plus four. Each enabled phase-two line gives a one-cycle update strobe together with its value, which a downstream tracker of shared lines counts.

Top module: `irq_drvbk_decoder`

## Requirements
- R1: After reset all ISA IRQ outputs are 0, smi_req and nmi_req are 0, and every phase-two strobe is 0.
- R2: A beat at address BASE with cyc_wdata[16+i]=0 sets isa_irq[i] to cyc_wdata[i] (1 = active) on the clock edge that accepts the beat, for every i other than 2 and 13.
- R3: In a beat at BASE, a line whose enable bit cyc_wdata[16+i] is 1 keeps its previous level.
- R4: Bit 2 of a phase-one beat, when its enable (bit 18) is 0, sets smi_req to cyc_wdata[2]. isa_irq[2] always stays 0.
- R5: Bit 13 of a phase-one beat, when its enable (bit 29) is 0, sets nmi_req to cyc_wdata[13]. isa_irq[13] always stays 0.
- R6: A beat at BASE with cyc_more=1, followed on the next clock by a beat with cyc_start=0, decodes that second beat as phase two (address BASE+4).
- R7: A cycle that starts at BASE+4 is decoded as phase two only and leaves the ISA, SMI and NMI outputs unchanged.
- R8: In phase two, each PCI line k (0..3) with cyc_wdata[16+k]=0 raises pci_upd[k] for one cycle, with pci_val[k]=cyc_wdata[k]. A line with the enable at 1 gives no strobe.
- R9: In phase two, each ACPI event line k (0..3) with cyc_wdata[20+k]=0 raises evt_upd[k] for one cycle, with evt_val[k]=cyc_wdata[4+k].
- R10: Reserved bits (phase two bits 8-15 and 24-31) have no effect on any output.
- R11: A data beat at any address other than BASE or BASE+4 is discarded. A data beat with no open cycle is also discarded.
- R12: Each strobe is high for exactly the one cycle after its beat and then returns to 0.
- R13: A phase-one beat raises no phase-two strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Opens a driveback cycle; cyc_addr is valid |
| cyc_addr | input | 16 | Byte address of the first beat |
| cyc_wdata | input | 32 | Beat data: values low, active-low enables high |
| cyc_wvalid | input | 1 | A data beat is present this cycle |
| cyc_more | input | 1 | Another beat follows this one |
| isa_irq | output | 16 | ISA interrupt levels for an edge-mode controller |
| smi_req | output | 1 | System-management request level (from IRQ2) |
| nmi_req | output | 1 | Non-maskable request level (from IRQ13) |
| pci_upd | output | 4 | One-cycle update strobes for PCI lines 0-3 |
| pci_val | output | 4 | Requested PCI line values, valid with pci_upd |
| evt_upd | output | 4 | One-cycle update strobes for ACPI events 0-3 |
| evt_val | output | 4 | Requested event values, valid with evt_upd |

## Verification
A wrong address pointer shows up at once as a burst beat that is dropped or misrouted. The phase-two strobes then stay low, or the ISA levels change, on the very cycle after that second beat. A wrong held level in the ISA registers persists and stays visible on isa_irq until that line is written again. The bench therefore compares every output against its model after every beat and again on the following idle cycle. An enable-bit or bit-lane mistake appears one cycle after the beat as a mismatched level or strobe. A strobe that sticks shows up as a non-zero strobe on that idle cycle.

// File: rtl/irq_drvbk_pkg.sv
package irq_drvbk_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned HALF_W     = 16;
   localparam int unsigned ISA_LINES  = 16;
   localparam int unsigned PCI_LINES  = 4;
   localparam int unsigned EVT_LINES  = 4;
   localparam int unsigned PCI_VAL_LO = 0;
   localparam int unsigned EVT_VAL_LO = 4;
   localparam int unsigned PCI_EN_LO  = HALF_W + PCI_VAL_LO;
   localparam int unsigned EVT_EN_LO  = HALF_W + EVT_VAL_LO;
   localparam int unsigned STEP_BYTES = 4;

   typedef enum logic [1:0] {
      PH_NONE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } phase_e;
endpackage

// File: rtl/irq_drvbk_addr.sv
module irq_drvbk_addr
   import irq_drvbk_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h0C00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              cyc_wvalid,
   input  logic              cyc_more,
   output phase_e            phase
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(STEP_BYTES);
   localparam logic [ADDR_W-1:0] BASE2 = BASE + STEP;

   generate
      if (BASE[1:0] != 2'b00) begin : g_bad_base
         $error("BASE must be aligned to a 32-bit word");
      end
   endgenerate

   logic              open_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] eff_addr;
   logic              beat;

   assign eff_addr = cyc_start ? cyc_addr : ptr_q;
   assign beat     = cyc_wvalid && (cyc_start || open_q);

   always_comb begin
      phase = PH_NONE;
      if (beat) begin
         if (eff_addr == BASE)       phase = PH_ONE;
         else if (eff_addr == BASE2) phase = PH_TWO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         ptr_q  <= '0;
      end else if (beat) begin
         open_q <= cyc_more;
         ptr_q  <= eff_addr + STEP;
      end else if (cyc_start) begin
         open_q <= 1'b1;
         ptr_q  <= cyc_addr;
      end
   end

   // R6: a burst continuation after phase one lands on phase two
   p_burst_to_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ONE && cyc_more) ##1 (cyc_wvalid && !cyc_start) |-> phase == PH_TWO);

   // R11: a beat with no open cycle and no start is never decoded
   p_no_stray_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_q && !cyc_start) |-> phase == PH_NONE);
endmodule

// File: rtl/irq_drvbk_isa.sv
module irq_drvbk_isa
   import irq_drvbk_pkg::*;
#(
   parameter int unsigned SMI_LINE = 2,
   parameter int unsigned NMI_LINE = 13,
   parameter bit          REDIRECT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit,
   input  logic [WORD_W-1:0]    wdata,
   output logic [ISA_LINES-1:0] isa_irq,
   output logic                 smi_req,
   output logic                 nmi_req
);
   generate
      if (SMI_LINE >= ISA_LINES || NMI_LINE >= ISA_LINES || SMI_LINE == NMI_LINE) begin : g_bad_map
         $error("redirected lines must be distinct and within range");
      end
   endgenerate

   logic [ISA_LINES-1:0] val;
   logic [ISA_LINES-1:0] en_n;
   assign val  = wdata[ISA_LINES-1:0];
   assign en_n = wdata[HALF_W +: ISA_LINES];

   generate
      for (genvar i = 0; i < ISA_LINES; i++) begin : g_line
         if (REDIRECT && (i == SMI_LINE || i == NMI_LINE)) begin : g_held_low
            assign isa_irq[i] = 1'b0;
         end else begin : g_level
            logic lvl_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                lvl_q <= 1'b0;
               else if (hit && !en_n[i])  lvl_q <= val[i];
            end
            assign isa_irq[i] = lvl_q;
         end
      end

      if (REDIRECT) begin : g_redirect
         logic smi_q, nmi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               smi_q <= 1'b0;
               nmi_q <= 1'b0;
            end else if (hit) begin
               if (!en_n[SMI_LINE]) smi_q <= val[SMI_LINE];
               if (!en_n[NMI_LINE]) nmi_q <= val[NMI_LINE];
            end
         end
         assign smi_req = smi_q;
         assign nmi_req = nmi_q;

         // R4: enabled bit of the SMI slot sets smi_req
         p_smi_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !en_n[SMI_LINE]) |=> smi_req == $past(val[SMI_LINE]));
         // R5: enabled bit of the NMI slot sets nmi_req
         p_nmi_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !en_n[NMI_LINE]) |=> nmi_req == $past(val[NMI_LINE]));
      end else begin : g_plain
         assign smi_req = 1'b0;
         assign nmi_req = 1'b0;
      end
   endgenerate

   // R3, R11: without a phase-one beat nothing moves
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(isa_irq) && $stable(smi_req) && $stable(nmi_req));

   // R3: a masked line keeps its level through a beat
   p_masked_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && en_n == '1) |=> $stable(isa_irq));
endmodule

// File: rtl/irq_drvbk_lvl.sv
module irq_drvbk_lvl
   import irq_drvbk_pkg::*;
#(
   parameter int unsigned LINES  = 4,
   parameter int unsigned VAL_LO = 0,
   parameter int unsigned EN_LO  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [WORD_W-1:0] wdata,
   output logic [LINES-1:0]  upd,
   output logic [LINES-1:0]  val
);
   generate
      if (VAL_LO + LINES > HALF_W || EN_LO + LINES > WORD_W || EN_LO < HALF_W) begin : g_bad_lane
         $error("line lanes fall outside the beat word");
      end
   endgenerate

   generate
      for (genvar k = 0; k < LINES; k++) begin : g_line
         logic upd_q, val_q, req;
         assign req = hit && !wdata[EN_LO + k];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               upd_q <= 1'b0;
               val_q <= 1'b0;
            end else begin
               upd_q <= req;
               if (req) val_q <= wdata[VAL_LO + k];
            end
         end
         assign upd[k] = upd_q;
         assign val[k] = val_q;

         // R8, R9: a disabled line never strobes
         p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wdata[EN_LO + k]) |=> !upd[k]);
      end
   endgenerate

   // R12: strobes appear only in the cycle after a phase-two beat
   p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> upd == '0);
endmodule

// File: rtl/irq_drvbk_decoder.sv
module irq_drvbk_decoder
   import irq_drvbk_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h0C00,
   parameter int unsigned SMI_LINE = 2,
   parameter int unsigned NMI_LINE = 13,
   parameter bit          REDIRECT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cyc_start,
   input  logic [ADDR_W-1:0]    cyc_addr,
   input  logic [WORD_W-1:0]    cyc_wdata,
   input  logic                 cyc_wvalid,
   input  logic                 cyc_more,
   output logic [ISA_LINES-1:0] isa_irq,
   output logic                 smi_req,
   output logic                 nmi_req,
   output logic [PCI_LINES-1:0] pci_upd,
   output logic [PCI_LINES-1:0] pci_val,
   output logic [EVT_LINES-1:0] evt_upd,
   output logic [EVT_LINES-1:0] evt_val
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address too narrow for two beats");
      end
   endgenerate

   phase_e phase;
   logic   hit_one, hit_two;

   irq_drvbk_addr #(.ADDR_W(ADDR_W), .BASE(BASE)) u_addr (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_wvalid(cyc_wvalid), .cyc_more(cyc_more), .phase(phase)
   );

   assign hit_one = (phase == PH_ONE);
   assign hit_two = (phase == PH_TWO);

   irq_drvbk_isa #(.SMI_LINE(SMI_LINE), .NMI_LINE(NMI_LINE), .REDIRECT(REDIRECT)) u_isa (
      .clk(clk), .rst_n(rst_n), .hit(hit_one), .wdata(cyc_wdata),
      .isa_irq(isa_irq), .smi_req(smi_req), .nmi_req(nmi_req)
   );

   irq_drvbk_lvl #(.LINES(PCI_LINES), .VAL_LO(PCI_VAL_LO), .EN_LO(PCI_EN_LO)) u_pci (
      .clk(clk), .rst_n(rst_n), .hit(hit_two), .wdata(cyc_wdata),
      .upd(pci_upd), .val(pci_val)
   );

   irq_drvbk_lvl #(.LINES(EVT_LINES), .VAL_LO(EVT_VAL_LO), .EN_LO(EVT_EN_LO)) u_evt (
      .clk(clk), .rst_n(rst_n), .hit(hit_two), .wdata(cyc_wdata),
      .upd(evt_upd), .val(evt_val)
   );

   // R13: phase one and phase two never share a beat
   p_one_phase_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hit_one |=> (pci_upd == '0) && (evt_upd == '0));

   // R7: a phase-two beat leaves the ISA side untouched
   p_two_keeps_isa_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_two |=> $stable(isa_irq) && $stable(smi_req) && $stable(nmi_req));
endmodule

// File: tb/irq_drvbk_decoder_tb.sv
module irq_drvbk_decoder_tb;
   localparam logic [15:0] BASE = 16'h0C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start = 1'b0;
   logic [15:0] cyc_addr = '0;
   logic [31:0] cyc_wdata = '0;
   logic        cyc_wvalid = 1'b0;
   logic        cyc_more = 1'b0;
   logic [15:0] isa_irq;
   logic        smi_req, nmi_req;
   logic [3:0]  pci_upd, pci_val, evt_upd, evt_val;

   int n_run = 0;
   int n_fail = 0;
   logic [15:0] m_isa = '0;
   logic        m_smi = 1'b0, m_nmi = 1'b0;

   always #5 clk = ~clk;

   irq_drvbk_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_wdata(cyc_wdata), .cyc_wvalid(cyc_wvalid), .cyc_more(cyc_more),
      .isa_irq(isa_irq), .smi_req(smi_req), .nmi_req(nmi_req),
      .pci_upd(pci_upd), .pci_val(pci_val), .evt_upd(evt_upd), .evt_val(evt_val)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_p1(input logic [31:0] d);
      for (int i = 0; i < 16; i++) begin
         if (!d[16+i]) begin
            if (i == 2)       m_smi = d[2];
            else if (i == 13) m_nmi = d[13];
            else              m_isa[i] = d[i];
         end
      end
   endfunction

   task automatic idle();
      cyc_start = 1'b0; cyc_wvalid = 1'b0; cyc_more = 1'b0;
   endtask

   task automatic drive(input logic st, input logic [15:0] a, input logic [31:0] d, input logic more);
      cyc_start = st; cyc_addr = a; cyc_wdata = d; cyc_wvalid = 1'b1; cyc_more = more;
   endtask

   task automatic chk_isa(input string req);
      chk(req, {16'h0, isa_irq}, {16'h0, m_isa});
      chk(req, {30'h0, smi_req, nmi_req}, {30'h0, m_smi, m_nmi});
   endtask

   task automatic chk_p2(input string req, input logic [31:0] d);
      logic [3:0] pe, ee;
      pe = ~d[19:16];
      ee = ~d[23:20];
      chk({req, " R8 pci_upd"}, {28'h0, pci_upd}, {28'h0, pe});
      chk({req, " R8 pci_val"}, {28'h0, pci_val & pe}, {28'h0, d[3:0] & pe});
      chk({req, " R9 evt_upd"}, {28'h0, evt_upd}, {28'h0, ee});
      chk({req, " R9 evt_val"}, {28'h0, evt_val & ee}, {28'h0, d[7:4] & ee});
   endtask

   task automatic chk_quiet(input string req);
      chk(req, {24'h0, pci_upd, evt_upd}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      logic [15:0] bad [4];
      bad[0] = BASE + 16'd8; bad[1] = BASE - 16'd4; bad[2] = BASE + 16'd2; bad[3] = 16'h0000;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_isa("R1 reset");
      chk_quiet("R1 reset strobes");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5 R13: phase-one sweep with varied enables
      for (int n = 0; n < 600; n++) begin
         d = (n * 32'h9E3779B1) ^ (n << 7) ^ 32'h5A5A_3C3C;
         if (n % 7 == 0) d[31:16] = 16'hFFFF;
         drive(1'b1, BASE, d, 1'b0);
         @(negedge clk);
         idle();
         model_p1(d);
         chk_isa("R2 R3 R4 R5 phase one");
         chk_quiet("R13 no strobe on phase one");
         chk("R4 R5 redirected slots low", {30'h0, isa_irq[13], isa_irq[2]}, 32'h0);
         @(negedge clk);
      end

      // R7 R8 R9 R10 R12: direct phase two, all enable patterns
      for (int e = 0; e < 256; e++) begin
         d = {8'(e * 29 + 3), 4'(e), 4'(e >> 4), 8'(e * 53), 4'(e * 11), 4'(e * 7 + 1)};
         d[23:16] = 8'(e);
         drive(1'b1, BASE + 16'd4, d, 1'b0);
         @(negedge clk);
         idle();
         chk_p2("R7 direct", d);
         chk_isa("R7 isa unchanged");
         @(negedge clk);
         chk_quiet("R12 one-cycle strobe");
      end

      // R6: burst of phase one then phase two
      for (int e = 0; e < 256; e++) begin
         d  = (e * 32'h0101_7F35) ^ 32'h00F0_0000;
         d2 = {8'(e * 91), 8'(255 - e), 8'(e * 3), 8'(e * 5 + 9)};
         drive(1'b1, BASE, d, 1'b1);
         @(negedge clk);
         model_p1(d);
         chk_isa("R6 burst phase one");
         drive(1'b0, 16'h0000, d2, 1'b0);
         @(negedge clk);
         idle();
         chk_p2("R6 burst phase two", d2);
         chk_isa("R6 isa after phase two");
         @(negedge clk);
         chk_quiet("R12 burst strobe drop");
      end

      // R11: foreign addresses and stray beats
      for (int b = 0; b < 4; b++) begin
         drive(1'b1, bad[b], 32'h0000_FFFF, 1'b0);
         @(negedge clk);
         idle();
         chk_isa("R11 foreign address isa");
         chk_quiet("R11 foreign address strobes");
         @(negedge clk);
      end
      drive(1'b0, BASE, 32'h0000_FFFF, 1'b0);
      @(negedge clk);
      idle();
      chk_isa("R11 beat without cycle");
      chk_quiet("R11 beat without cycle strobes");
      @(negedge clk);

      // R10: reserved bits alone change nothing
      drive(1'b1, BASE + 16'd4, 32'hFF0F_FF0F ^ 32'h00F0_00F0 | 32'h00FF_0000, 1'b0);
      @(negedge clk);
      idle();
      chk_quiet("R10 reserved only");
      chk_isa("R10 reserved only isa");
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule